// File: doc/BRIEF.md
# Keyboard Character Input Port

This block is a memory-mapped input port placed between a keyboard encoder and a processor bus. The encoder presents a character code together with a strobe that rises once per key press. On each rising edge of that strobe the port captures the code into a character register and raises a "character ready" flag.

The processor reaches the port through an asynchronous read handshake. It drives an address, a read/write direction and a master-side ready line, and the port answers with a slave-side ready line and a read-data word with an output enable. Two word addresses are decoded. The low address bit picks either the status word, which carries the ready flag in bit 0, or the character register. Completing a read of the character register clears the ready flag. The strobe and the master-side ready line are brought into the clock domain by multi-stage synchronizers. Bus drivers are modelled as a data word plus an enable, with the word forced to zero while the enable is low.

Top module: `kbd_input_port`

## Requirements
- R1: After synchronous reset the character register and the ready flag are 0, and `bus_srdy`, `bus_oe` and `bus_rdata` are all 0.
- R2: A 0-to-1 transition of `key_valid` loads `key_code` into the character register and sets the ready flag. With two synchronizer stages, both are updated at the third rising clock edge after the transition.
- R3: A read with address bit 0 = 0 returns the status word. The ready flag is in bit 0 and all other bits are 0. A status read leaves the flag unchanged.
- R4: A read with address bit 0 = 1 returns the character register, zero-extended to the width of `bus_rdata`.
- R5: The ready flag clears once a character-register read completes. A read completes when the synchronized `bus_mrdy` falls after the read was answered.
- R6: The port responds only when `bus_addr[31:1]` equals `BASE_ADDR[31:1]`. Any other address gets no `bus_srdy`, and the register state is left unchanged.
- R7: `bus_srdy` is high exactly while a decoded status read or data read is active, and `bus_oe` follows it. At most one of the two read selects is active at a time, and `bus_rdata` is 0 whenever `bus_oe` is low.
- R8: Writes (`bus_rd` = 0) are ignored. They never raise `bus_srdy` and never change the character register or the ready flag.
- R9: A new `key_valid` rising edge while the ready flag is set overwrites the character register, and the flag stays set.
- R10: Holding `key_valid` high does not reload the register, even if `key_code` changes. Only a rising edge loads it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_code | input | CODE_W | Character code from the encoder |
| key_valid | input | 1 | Key-press strobe from the encoder |
| bus_addr | input | 32 | Bus address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_mrdy | input | 1 | Master-side ready of the handshake |
| bus_srdy | output | 1 | Slave-side ready of the handshake |
| bus_oe | output | 1 | Read-data output enable |
| bus_rdata | output | DATA_W | Read-data word |

## Verification
The bench builds the port with an 8-bit code, a 32-bit data word, two synchronizer stages and a base address of 0x4000_0010. With this configuration it can sweep all 256 character codes through the full capture, status-read, data-read and clear cycle. It can also flip each of the 31 decoded address bits one at a time to show that no neighbouring address is answered. The short synchronizers keep every handshake to a handful of cycles, so the overwrite, held-strobe and write-rejection cases can run alongside the full code sweep.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;

    localparam int ADDR_W = 32;

    // Register picked by the low address bit
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_DATA   = 1'b1
    } reg_sel_e;

    // Decoded read selects
    typedef struct packed {
        logic rd_data;
        logic rd_stat;
    } rd_sel_t;

    // Word match on every address bit above bit 0
    function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] base);
        return a[ADDR_W-1:1] == base[ADDR_W-1:1];
    endfunction

    function automatic reg_sel_e reg_of(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[0]);
    endfunction

endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/kbd_capture.sv
module kbd_capture #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_s,
    input  logic [CODE_W-1:0] code_i,
    input  logic              clr_i,
    output logic [CODE_W-1:0] data_o,
    output logic              sin_o
);
    logic              strobe_d;
    logic              rise;
    logic [CODE_W-1:0] data_q;
    logic              sin_q;

    assign rise = strobe_s & ~strobe_d;

    // A new character wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_d <= 1'b0;
            data_q   <= '0;
            sin_q    <= 1'b0;
        end else begin
            strobe_d <= strobe_s;
            if (rise) begin
                data_q <= code_i;
                sin_q  <= 1'b1;
            end else if (clr_i) begin
                sin_q  <= 1'b0;
            end
        end
    end

    assign data_o = data_q;
    assign sin_o  = sin_q;

    // R2 / R9: a rising strobe loads the code and leaves the flag set
    a_r2_rise_loads: assert property (@(posedge clk) disable iff (rst)
        rise |=> (sin_q && data_q == $past(code_i)));

    // R10: the register changes only after an edge
    a_r10_load_on_edge_only: assert property (@(posedge clk) disable iff (rst)
        (data_q != $past(data_q)) |-> $past(rise));

    // R5: the flag drops only on a completed data read
    a_r5_clear_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(sin_q) |-> ($past(clr_i) && !$past(rise)));
endmodule

// File: rtl/kbd_bus_decode.sv
module kbd_bus_decode
    import kbd_port_pkg::*;
#(
    parameter int              CODE_W    = 8,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              mrdy_s,
    input  logic [CODE_W-1:0] data_i,
    input  logic              sin_i,
    output logic              srdy_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              clr_o
);
    rd_sel_t sel;
    logic    hit;
    logic    pend;

    assign hit         = addr_hit(addr_i, BASE_ADDR) & rd_i & mrdy_s;
    assign sel.rd_data = hit & (reg_of(addr_i) == SEL_DATA);
    assign sel.rd_stat = hit & (reg_of(addr_i) == SEL_STATUS);

    assign srdy_o = sel.rd_data | sel.rd_stat;
    assign oe_o   = srdy_o;

    always_comb begin
        rdata_o = '0;
        if (sel.rd_data)      rdata_o[CODE_W-1:0] = data_i;
        else if (sel.rd_stat) rdata_o[0]          = sin_i;
    end

    // Remember an answered data read until master-ready drops
    always_ff @(posedge clk) begin
        if (rst)              pend <= 1'b0;
        else if (sel.rd_data) pend <= 1'b1;
        else if (!mrdy_s)     pend <= 1'b0;
    end

    assign clr_o = pend & ~mrdy_s;

    // R7: the two selects never overlap
    a_r7_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel.rd_data, sel.rd_stat}));

    // R8: no answer to a write
    a_r8_no_srdy_on_write: assert property (@(posedge clk) disable iff (rst)
        srdy_o |-> rd_i);

    // R3: unused status bits stay zero
    a_r3_status_upper_zero: assert property (@(posedge clk) disable iff (rst)
        sel.rd_stat |-> (rdata_o[DATA_W-1:1] == '0));

    // R5: a clear follows an answered data read
    a_r5_clear_after_read: assert property (@(posedge clk) disable iff (rst)
        clr_o |-> $past(sel.rd_data || pend));
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
    import kbd_port_pkg::*;
#(
    parameter int                CODE_W      = 8,
    parameter int                DATA_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h4000_0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] key_code,
    input  logic              key_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_mrdy,
    output logic              bus_srdy,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int N_SYNC = 2;

    logic [N_SYNC-1:0] async_in;
    logic [N_SYNC-1:0] synced;
    logic              valid_s;
    logic              mrdy_s;
    logic [CODE_W-1:0] data_q;
    logic              sin_q;
    logic              clr;

    assign async_in = {bus_mrdy, key_valid};
    assign valid_s  = synced[0];
    assign mrdy_s   = synced[1];

    kbd_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (async_in),
        .q   (synced)
    );

    kbd_capture #(.CODE_W(CODE_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .strobe_s (valid_s),
        .code_i   (key_code),
        .clr_i    (clr),
        .data_o   (data_q),
        .sin_o    (sin_q)
    );

    kbd_bus_decode #(
        .CODE_W    (CODE_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (bus_addr),
        .rd_i    (bus_rd),
        .mrdy_s  (mrdy_s),
        .data_i  (data_q),
        .sin_i   (sin_q),
        .srdy_o  (bus_srdy),
        .oe_o    (bus_oe),
        .rdata_o (bus_rdata),
        .clr_o   (clr)
    );

    // R7: a disabled bus carries zeros
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_rdata == '0));

    // R7: answers only while master-ready is held
    a_r7_srdy_needs_mrdy: assert property (@(posedge clk) disable iff (rst)
        bus_srdy |-> mrdy_s);
endmodule

// File: tb/kbd_input_port_bench.sv
module kbd_input_port_bench;
    localparam int          CODE_W = 8;
    localparam int          DATA_W = 32;
    localparam logic [31:0] BASE   = 32'h4000_0010;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CODE_W-1:0] key_code = '0;
    logic              key_valid = 1'b0;
    logic [31:0]       bus_addr = '0;
    logic              bus_rd = 1'b0;
    logic              bus_mrdy = 1'b0;
    logic              bus_srdy;
    logic              bus_oe;
    logic [DATA_W-1:0] bus_rdata;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    kbd_input_port #(
        .CODE_W      (CODE_W),
        .DATA_W      (DATA_W),
        .SYNC_STAGES (2),
        .BASE_ADDR   (BASE)
    ) u_kbd_input_port (
        .clk       (clk),
        .rst       (rst),
        .key_code  (key_code),
        .key_valid (key_valid),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_mrdy  (bus_mrdy),
        .bus_srdy  (bus_srdy),
        .bus_oe    (bus_oe),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Full read handshake; answered=0 when no slave-ready came back
    task automatic bus_read(input logic [31:0] a, output logic [31:0] d,
                            output logic answered, output logic oe_seen);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_mrdy = 1'b1;
        answered = 1'b0; d = '0; oe_seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (bus_srdy) begin
                answered = 1'b1; d = bus_rdata; oe_seen = bus_oe;
                break;
            end
        end
        bus_mrdy = 1'b0;
        repeat (4) @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Write attempt; returns 1 if slave-ready ever rose
    task automatic bus_write(input logic [31:0] a, output logic srdy_seen);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b0; bus_mrdy = 1'b1; srdy_seen = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (bus_srdy) srdy_seen = 1'b1;
        end
        bus_mrdy = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic key_press(input logic [CODE_W-1:0] c);
        @(negedge clk);
        key_code = c; key_valid = 1'b1;
        repeat (4) @(negedge clk);
        key_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic        ans, oe, sr;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        check("R1 srdy", {31'b0, bus_srdy}, 32'd0);
        check("R1 oe", {31'b0, bus_oe}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        bus_read(BASE, d, ans, oe);
        check("R1 status", d, 32'd0);
        bus_read(BASE | 32'd1, d, ans, oe);
        check("R1 data", d, 32'd0);

        // R2 timing: loaded at third edge after the rise
        @(negedge clk);
        key_code = 8'hA5; key_valid = 1'b1;
        bus_addr = BASE | 32'd1; bus_rd = 1'b1; bus_mrdy = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R2 srdy up", {31'b0, bus_srdy}, 32'd1);
        check("R2 not yet loaded", bus_rdata, 32'd0);
        @(negedge clk);
        check("R2 loaded at third edge", bus_rdata, 32'h0000_00A5);
        bus_mrdy = 1'b0; key_valid = 1'b0;
        repeat (4) @(negedge clk);
        bus_rd = 1'b0;
        bus_read(BASE, d, ans, oe);
        check("R5 cleared after data read", d, 32'd0);

        // R2/R3/R4/R5/R7: sweep every code
        for (int c = 0; c < 256; c++) begin
            key_press(CODE_W'(c));
            bus_read(BASE, d, ans, oe);
            check("R3 status set", d, 32'd1);
            check("R7 oe on status read", {31'b0, oe}, 32'd1);
            bus_read(BASE, d, ans, oe);
            check("R3 status read keeps flag", d, 32'd1);
            bus_read(BASE | 32'd1, d, ans, oe);
            check("R4 data value", d, 32'(c));
            check("R7 srdy on data read", {31'b0, ans}, 32'd1);
            bus_read(BASE, d, ans, oe);
            check("R5 flag cleared", d, 32'd0);
            check("R7 idle rdata", bus_rdata, 32'd0);
        end

        // R6: every single-bit deviation of the decoded address
        key_press(8'h3C);
        for (int b = 1; b < 32; b++) begin
            bus_read(BASE ^ (32'd1 << b), d, ans, oe);
            check("R6 no answer off-address", {31'b0, ans}, 32'd0);
            bus_read((BASE ^ (32'd1 << b)) | 32'd1, d, ans, oe);
            check("R6 no answer off-address data", {31'b0, ans}, 32'd0);
        end
        bus_read(BASE, d, ans, oe);
        check("R6 flag untouched", d, 32'd1);

        // R8: writes to both registers
        bus_write(BASE, sr);
        check("R8 no srdy status write", {31'b0, sr}, 32'd0);
        bus_write(BASE | 32'd1, sr);
        check("R8 no srdy data write", {31'b0, sr}, 32'd0);
        bus_read(BASE, d, ans, oe);
        check("R8 flag kept", d, 32'd1);

        // R9: overwrite while flag set
        key_press(8'h7E);
        bus_read(BASE, d, ans, oe);
        check("R9 flag stays set", d, 32'd1);
        bus_read(BASE | 32'd1, d, ans, oe);
        check("R9 newest code", d, 32'h7E);
        bus_read(BASE | 32'd1, d, ans, oe);
        check("R8 data after write", d, 32'h7E);

        // R10: held strobe with changing code
        @(negedge clk);
        key_code = 8'h11; key_valid = 1'b1;
        repeat (5) @(negedge clk);
        key_code = 8'h22;
        repeat (5) @(negedge clk);
        bus_read(BASE | 32'd1, d, ans, oe);
        check("R10 no reload while held", d, 32'h11);
        bus_read(BASE, d, ans, oe);
        check("R10 flag cleared, no new edge", d, 32'd0);
        key_valid = 1'b0;
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule